// File: doc/BRIEF.md
# Fourteen-Stage Binary Frequency Divider

This block divides an incoming clock by powers of two through fourteen stages. Each stage runs at half the rate of the one before it, and the first stage runs at half the input rate. The clock input stands in for an oscillator. An output called `osc_run` represents the oscillator run control. The stage chain is built as one synchronous counter that advances on the falling edge of the clock, so every stage output changes in the same instant.

An active-high asynchronous reset clears every stage at once and drops `osc_run` so that the oscillator can stop. After reset is released, a short synchroniser on the falling edge restarts the count.

Only ten of the fourteen stages appear on the port. Stages 1 to 3 and stage 11 stay internal. A compare input chooses one count value. The block raises a decode strobe for that value, gated by the clock-high phase so that it cannot glitch while the stages change.

There is no streaming data path, so there is no valid/ready handshake and no back-pressure. All pins are plain level signals.

Top module: `stage_divider`

## Requirements
- R1: `taps` bits 0 to 6 carry stages 4 to 10 and bits 7 to 9 carry stages 12 to 14, where stage k is bit k-1 of the internal count. Stages 1, 2, 3 and 11 appear on no pin, so a count with only those stages set shows `taps` = 0.
- R2: Once counting, the internal count rises by exactly one on every falling edge of `clk_in`. A rising edge changes no output bit.
- R3: The count wraps from 16383 to 0, so the full sequence repeats every 16384 input clock periods and stage 14 toggles every 8192 periods.
- R4: While `rst` is high, `taps` is 0 at once, without waiting for a clock edge, and stays 0 through any number of clock edges.
- R5: `osc_run` is low whenever `rst` is high and goes high as soon as `rst` is low, with no clock edge needed.
- R6: After `rst` falls, the count holds 0 through the first two falling edges and becomes 1 on the third falling edge.
- R7: `dec_strobe` can be high only during a clock-high phase. It is high in the clock-high phase that follows a falling edge when, after that edge, the count equals `cmp_val` and the release synchroniser has completed. It is low in every clock-low phase.
- R8: With `cmp_val` fixed and no reset, `dec_strobe` pulses in exactly one clock-high phase per 16384 clock periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock standing in for the oscillator; the count advances on its falling edge |
| rst | input | 1 | Asynchronous reset, active high; clears the count and halts the oscillator |
| cmp_val | input | 14 | Count value that the decode strobe is looking for |
| osc_run | output | 1 | Oscillator run control; low while reset is asserted |
| taps | output | 10 | Exposed stage outputs packed in ascending stage order (see R1) |
| dec_strobe | output | 1 | Decode strobe gated by the clock-high phase |

## Verification
The bound checker checks, at every edge, that the count steps by one on each running falling edge, that it holds while the synchroniser is filling, and that the outermost tap bits follow their stages. It also checks that reset clears the taps and drops `osc_run`, that the strobe is low in clock-low phases, and that it is high only on a true match. Some behaviour only the bench scenarios can show: the exact three-edge start-up after release, the complete packing of all ten taps across a full wrap, the hiding of stage 11, and a single strobe per 16384-cycle wrap. The bench predicts every clock-high phase from its own model of edge counts and compares the outputs to that prediction.

// File: rtl/stage_div_pkg.sv
package stage_div_pkg;

  // Number of stages that reach the port: stages first..stages, minus the hidden one.
  function automatic int tap_count(input int stages, input int first, input int hidden);
    return stages - first + 1 - (((hidden >= first) && (hidden <= stages)) ? 1 : 0);
  endfunction

  // Port slot used by a given stage number (stage numbers start at 1).
  function automatic int tap_slot(input int stage, input int first, input int hidden);
    return stage - first - (((stage > hidden) && (hidden >= first)) ? 1 : 0);
  endfunction

endpackage

// File: rtl/sd_release_sync.sv
module sd_release_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk_in,
  input  logic rst,
  output logic run_en
);
  logic [DEPTH-1:0] stage_q;

  // The chain is cleared at once and refills one stage per falling edge.
  always_ff @(negedge clk_in or posedge rst) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[DEPTH-2:0], 1'b1};
  end

  assign run_en = stage_q[DEPTH-1];
endmodule

// File: rtl/sd_count_core.sv
module sd_count_core #(
  parameter int W = 14
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic         run_en,
  output logic [W-1:0] count_q
);
  localparam logic [W-1:0] STEP = W'(1);

  // All stages advance together on the falling edge; no ripple.
  always_ff @(negedge clk_in or posedge rst) begin
    if (rst)         count_q <= '0;
    else if (run_en) count_q <= count_q + STEP;
  end
endmodule

// File: rtl/sd_tap_select.sv
module sd_tap_select import stage_div_pkg::*; #(
  parameter int W      = 14,
  parameter int FIRST  = 4,
  parameter int HIDDEN = 11,
  localparam int TW    = tap_count(W, FIRST, HIDDEN)
) (
  input  logic [W-1:0]  count_q,
  output logic [TW-1:0] taps
);
  logic [W-1:0] kept_mask;

  for (genvar s = 1; s <= W; s++) begin : g_stage
    if ((s >= FIRST) && (s != HIDDEN)) begin : g_out
      assign taps[tap_slot(s, FIRST, HIDDEN)] = count_q[s-1];
      assign kept_mask[s-1] = 1'b1;
    end else begin : g_in
      assign kept_mask[s-1] = 1'b0;
    end
  end

  // The internal stages are present in the count but reach no pin.
  logic unused_inner;
  assign unused_inner = ^(count_q & ~kept_mask);
endmodule

// File: rtl/sd_decode_gate.sv
module sd_decode_gate #(
  parameter int W = 14
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic         run_en,
  input  logic [W-1:0] count_q,
  input  logic [W-1:0] cmp_val,
  output logic         dec_strobe
);
  logic hit_q;

  // The match is captured at the rising edge, half a period after the count
  // settles, and is let through only while the clock stays high.
  always_ff @(posedge clk_in or posedge rst) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= run_en && (count_q == cmp_val);
  end

  assign dec_strobe = hit_q & clk_in;
endmodule

// File: rtl/stage_divider.sv
module stage_divider import stage_div_pkg::*; #(
  parameter int  STAGES     = 14,
  parameter int  FIRST_TAP  = 4,
  parameter int  HIDDEN_TAP = 11,
  parameter int  SYNC_DEPTH = 2,
  localparam int TAP_W      = tap_count(STAGES, FIRST_TAP, HIDDEN_TAP)
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic [STAGES-1:0] cmp_val,
  output logic              osc_run,
  output logic [TAP_W-1:0]  taps,
  output logic              dec_strobe
);
  logic              run_en;
  logic [STAGES-1:0] count_q;

  // Oscillator halts for as long as reset is held.
  assign osc_run = ~rst;

  sd_release_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_in (clk_in),
    .rst    (rst),
    .run_en (run_en)
  );

  sd_count_core #(.W(STAGES)) u_core (
    .clk_in  (clk_in),
    .rst     (rst),
    .run_en  (run_en),
    .count_q (count_q)
  );

  sd_tap_select #(.W(STAGES), .FIRST(FIRST_TAP), .HIDDEN(HIDDEN_TAP)) u_taps (
    .count_q (count_q),
    .taps    (taps)
  );

  sd_decode_gate #(.W(STAGES)) u_dec (
    .clk_in     (clk_in),
    .rst        (rst),
    .run_en     (run_en),
    .count_q    (count_q),
    .cmp_val    (cmp_val),
    .dec_strobe (dec_strobe)
  );
endmodule

// File: rtl/stage_divider_chk.sv
module stage_divider_chk #(
  parameter int W     = 14,
  parameter int TW    = 10,
  parameter int FIRST = 4
) (
  input logic          clk_in,
  input logic          rst,
  input logic [W-1:0]  cmp_val,
  input logic          osc_run,
  input logic [TW-1:0] taps,
  input logic          dec_strobe,
  input logic [W-1:0]  count_q,
  input logic          run_en
);
  // R2: a running falling edge adds exactly one (modulo the stage count, R3)
  p_step_by_one_r2: assert property (@(negedge clk_in) disable iff (rst)
    run_en |=> (count_q == W'($past(count_q) + W'(1))));

  // R6: while the release chain fills, the count does not move
  p_hold_at_start_r6: assert property (@(negedge clk_in) disable iff (rst)
    !run_en |=> $stable(count_q));

  // R1: outermost port bits follow their stages
  p_tap_edges_r1: assert property (@(posedge clk_in) disable iff (rst)
    (taps[0] == count_q[FIRST-1]) && (taps[TW-1] == count_q[W-1]));

  // R4 and R5: reset clears the taps and halts the oscillator
  p_reset_clears_r4: assert property (@(posedge clk_in)
    rst |-> ((taps == '0) && !osc_run));

  // R5: the oscillator runs whenever reset is low
  p_run_when_free_r5: assert property (@(posedge clk_in)
    !rst |-> osc_run);

  // R7: the strobe is low when sampled at the end of a clock-low phase
  p_low_phase_quiet_r7: assert property (@(posedge clk_in) disable iff (rst)
    !dec_strobe);

  // R7: the strobe in a high phase means a real match while running
  p_strobe_matches_r7: assert property (@(negedge clk_in) disable iff (rst)
    dec_strobe |-> (run_en && (count_q == cmp_val)));
endmodule

bind stage_divider stage_divider_chk #(.W(STAGES), .TW(TAP_W), .FIRST(FIRST_TAP)) u_chk (
  .clk_in     (clk_in),
  .rst        (rst),
  .cmp_val    (cmp_val),
  .osc_run    (osc_run),
  .taps       (taps),
  .dec_strobe (dec_strobe),
  .count_q    (count_q),
  .run_en     (run_en)
);

// File: tb/stage_divider_bench.sv
`timescale 1ns/1ps
module stage_divider_bench;
  logic        clk;
  logic        rst;
  logic [13:0] cmp_val;
  logic        osc_run;
  logic [9:0]  taps;
  logic        dec_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  int stb_seen = 0;
  bit done     = 0;

  // Bench-side model state
  int       m_fall;
  logic [13:0] m_cnt;

  logic [9:0] q_taps[$];
  logic       q_stb[$];
  string      q_tag[$];

  stage_divider u_stage_divider (
    .clk_in     (clk),
    .rst        (rst),
    .cmp_val    (cmp_val),
    .osc_run    (osc_run),
    .taps       (taps),
    .dec_strobe (dec_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Packing from R1: slots 0..6 = stages 4..10, slots 7..9 = stages 12..14
  function automatic logic [9:0] pack(input logic [13:0] c);
    logic [9:0] p;
    for (int k = 0; k < 7; k++) p[k] = c[k+3];
    for (int k = 0; k < 3; k++) p[7+k] = c[k+11];
    return p;
  endfunction

  // Driver: after every falling edge, predict the following high phase
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      m_fall++;
      if (m_fall >= 3) m_cnt = m_cnt + 14'd1;   // R6 start-up, R2 step, R3 wrap
      q_taps.push_back(pack(m_cnt));
      q_stb.push_back((m_fall >= 2) && (m_cnt == cmp_val));
      if (m_fall <= 3)      q_tag.push_back("R6");
      else if (m_cnt < 14)  q_tag.push_back("R3");
      else                  q_tag.push_back("R1/R2");
    end
  endtask

  // Monitor: compare in the middle of each high phase
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_taps.size() > 0) begin
        logic [9:0] et;
        logic       es;
        string      tg;
        et = q_taps.pop_front();
        es = q_stb.pop_front();
        tg = q_tag.pop_front();
        chk(taps == et, tg, "taps", int'(taps), int'(et));
        chk(dec_strobe == es, "R7", "strobe high phase", int'(dec_strobe), int'(es));
        if (dec_strobe) stb_seen++;
      end
    end
  end

  // Low-phase monitor for R7
  initial begin
    forever begin
      @(negedge clk);
      #2;
      chk(dec_strobe == 1'b0, "R7", "strobe low phase", int'(dec_strobe), 0);
    end
  end

  task automatic hold_reset(input int n);
    @(posedge clk);
    #2.5;
    rst = 1'b1;
    #0.5;
    chk(taps == 10'd0, "R4", "taps at reset assert", int'(taps), 0);
    chk(osc_run == 1'b0, "R5", "osc_run at reset", int'(osc_run), 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      chk(taps == 10'd0, "R4", "taps through clocking", int'(taps), 0);
    end
    @(posedge clk);
    #1;
    rst    = 1'b0;
    m_fall = 0;
    m_cnt  = '0;
    #0.5;
    chk(osc_run == 1'b1, "R5", "osc_run after release", int'(osc_run), 1);
  endtask

  initial begin
    rst     = 1'b1;
    cmp_val = 14'd5;
    m_fall  = 0;
    m_cnt   = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(taps == 10'd0, "R4", "taps in reset", int'(taps), 0);
    chk(osc_run == 1'b0, "R5", "osc_run in reset", int'(osc_run), 0);
    chk(dec_strobe == 1'b0, "R7", "strobe in reset", int'(dec_strobe), 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    #0.5;
    chk(osc_run == 1'b1, "R5", "osc_run released", int'(osc_run), 1);

    // start-up, stepping and a small compare
    run(40);
    cmp_val = 14'd60;
    run(40);
    // stage 11 alone set (count 1024) shows as zero taps, R1
    cmp_val = 14'd1030;
    run(1000);

    // reset in the middle of a run, then a full wrap with the top compare value
    hold_reset(4);
    cmp_val  = 14'd16383;
    stb_seen = 0;
    run(16400);
    @(posedge clk);
    #3;
    chk(stb_seen == 1, "R8", "strobes per wrap", stb_seen, 1);

    hold_reset(2);
    run(10);
    @(posedge clk);
    #3;
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule